// File: doc/BRIEF.md
# Timer Interrupt Enable and Pending Register

This block is the interrupt control word shared by a group of timer channels (five by default). One register word carries a per-channel interrupt enable field and a per-channel pending field. Each channel delivers a single-cycle expiry pulse. A pulse always marks the channel pending. It raises the channel's level interrupt line only if that channel is enabled at that moment.

Software reads the whole word at any time on a combinational readback port. A write replaces the enable field outright. In the pending field, a write clears each bit written as one and leaves each bit written as zero. Clearing a pending bit releases that channel's interrupt line. Enabling a channel that is already pending does not raise its line, and disabling a channel whose line is up does not drop it; only a clear drops the line. The surrounding address decoder produces the write strobe and is outside this block.

Top module: `tmr_irq_csr`

## Requirements
- R1: While and after reset, with no writes and no events, the readback word is all zeros and every interrupt line is low.
- R2: A write loads bits [4:0] (channel n enable at bit n) with the written data, both setting and clearing; the new value is visible on the readback in the cycle after the write.
- R3: An expiry pulse on channel n sets pending bit 5+n in the next cycle, whether or not the channel is enabled.
- R4: An expiry pulse on channel n raises irq line n in the next cycle when enable bit n is set; with enable bit n clear, the line stays low.
- R5: In a write, a one in bit 5+n clears pending bit n in the next cycle, and a zero in bit 5+n leaves it unchanged.
- R6: When a pending bit is cleared by a write, that channel's interrupt line is low in the same cycle the pending bit reads zero.
- R7: Readback bits 31 down to 10 always read zero, and writing ones to them has no effect on any output.
- R8: If an expiry pulse and a clear of the same pending bit occur in one cycle, the pending bit stays set. The line is then raised if the channel was enabled, and otherwise it keeps its prior level.
- R9: An interrupt line rises only on an expiry pulse. Setting an enable while the channel is pending does not raise the line, and clearing an enable while the line is high does not lower it.
- R10: An expiry pulse is gated by the enable value held before a same-cycle write. Enabling in the pulse's cycle does not raise the line, and disabling in the pulse's cycle still raises it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| expire_i | input | NUM_CH | Per-channel expiry pulses, one cycle wide |
| wr_en_i | input | 1 | Write strobe for the register word |
| wr_data_i | input | DATA_W | Write data |
| rd_data_o | output | DATA_W | Register readback: enables [4:0], pending [9:5], zeros above |
| irq_o | output | NUM_CH | Per-channel level interrupt lines |

## Verification
The expiry pulse that sets a pending bit and the software write that clears it can fall in one cycle. The same holds for a pulse and a write that flips that channel's enable. The bench provokes both on purpose with directed cases for each channel position. It also runs a long pseudo-random walk in which pulses, clears and enable changes overlap freely. A bench model built from the rules above judges every cycle: the pulse wins over the clear, and the enable held before the write decides whether the line rises.

// File: rtl/tmr_irq_csr_pkg.sv
package tmr_irq_csr_pkg;
  localparam int DEF_NUM_CH = 5;
  localparam int DEF_DATA_W = 32;

  typedef struct packed {
    logic evt;
    logic clr;
  } chan_cmd_t;
endpackage

// File: rtl/tmr_irq_en_reg.sv
module tmr_irq_en_reg #(
  parameter int NUM_CH = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [NUM_CH-1:0] wr_val_i,
  output logic [NUM_CH-1:0] en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_o <= '0;
    else if (wr_en_i) en_o <= wr_val_i;
  end
endmodule

// File: rtl/tmr_irq_chan.sv
module tmr_irq_chan
  import tmr_irq_csr_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  chan_cmd_t cmd_i,
  input  logic      en_i,
  output logic      pend_o,
  output logic      irq_o
);
  logic pend_d, irq_d;

  // event wins over a same-cycle clear
  always_comb begin
    pend_d = pend_o;
    if (cmd_i.evt)      pend_d = 1'b1;
    else if (cmd_i.clr) pend_d = 1'b0;

    irq_d = irq_o;
    if (cmd_i.evt && en_i)        irq_d = 1'b1;
    else if (cmd_i.clr && !cmd_i.evt) irq_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      pend_o <= pend_d;
      irq_o  <= irq_d;
    end
  end
endmodule

// File: rtl/tmr_irq_rdmux.sv
module tmr_irq_rdmux #(
  parameter int NUM_CH = 5,
  parameter int DATA_W = 32
) (
  input  logic [NUM_CH-1:0] en_i,
  input  logic [NUM_CH-1:0] pend_i,
  output logic [DATA_W-1:0] rd_o
);
  localparam int USED_W = 2 * NUM_CH;

  always_comb begin
    rd_o = '0;
    rd_o[NUM_CH-1:0]      = en_i;
    rd_o[USED_W-1:NUM_CH] = pend_i;
  end
endmodule

// File: rtl/tmr_irq_csr.sv
module tmr_irq_csr
  import tmr_irq_csr_pkg::*;
#(
  parameter int NUM_CH = DEF_NUM_CH,
  parameter int DATA_W = DEF_DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] expire_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [NUM_CH-1:0] irq_o
);
  localparam int ST_LSB = NUM_CH;
  localparam int USED_W = 2 * NUM_CH;

  logic [NUM_CH-1:0] en_q;
  logic [NUM_CH-1:0] pend_q;
  logic [NUM_CH-1:0] clr_req;
  logic              unused_hi;

  assign clr_req   = wr_en_i ? wr_data_i[USED_W-1:ST_LSB] : '0;
  assign unused_hi = ^wr_data_i[DATA_W-1:USED_W];

  tmr_irq_en_reg #(.NUM_CH(NUM_CH)) u_en (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_val_i (wr_data_i[NUM_CH-1:0]),
    .en_o     (en_q)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    chan_cmd_t cmd;
    assign cmd.evt = expire_i[g];
    assign cmd.clr = clr_req[g];

    tmr_irq_chan u_ch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cmd_i  (cmd),
      .en_i   (en_q[g]),
      .pend_o (pend_q[g]),
      .irq_o  (irq_o[g])
    );
  end

  tmr_irq_rdmux #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_rd (
    .en_i   (en_q),
    .pend_i (pend_q),
    .rd_o   (rd_data_o)
  );
endmodule

// File: rtl/tmr_irq_csr_chk.sv
module tmr_irq_csr_chk #(
  parameter int NUM_CH = 5,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_CH-1:0] expire_i,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic [NUM_CH-1:0] irq_o
);
  localparam int USED_W = 2 * NUM_CH;

  logic unused_chk;
  assign unused_chk = ^wr_data_i;

  AST_HI_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[DATA_W-1:USED_W] == '0); // R7

  AST_EN_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rd_data_o[NUM_CH-1:0] == $past(wr_data_i[NUM_CH-1:0])); // R2

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    AST_EVT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      expire_i[g] |=> rd_data_o[NUM_CH+g]); // R3

    AST_EVT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      expire_i[g] && wr_en_i && wr_data_i[NUM_CH+g] |=> rd_data_o[NUM_CH+g]); // R8

    AST_IRQ_ON_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      expire_i[g] && rd_data_o[g] |=> irq_o[g]); // R4

    AST_IRQ_ONLY_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_o[g]) |-> $past(expire_i[g] && rd_data_o[g])); // R9

    AST_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i && wr_data_i[NUM_CH+g] && !expire_i[g] |=> !rd_data_o[NUM_CH+g]); // R5

    AST_W0_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_data_o[NUM_CH+g] && !(wr_en_i && wr_data_i[NUM_CH+g]) |=> rd_data_o[NUM_CH+g]); // R5

    AST_IRQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(rd_data_o[NUM_CH+g]) |-> !irq_o[g]); // R6
  end
endmodule

bind tmr_irq_csr tmr_irq_csr_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .expire_i  (expire_i),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .rd_data_o (rd_data_o),
  .irq_o     (irq_o)
);

// File: tb/sim_tmr_irq_csr.sv
module sim_tmr_irq_csr;
  localparam int N = 5;
  localparam int W = 32;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] expire_i = '0;
  logic         wr_en_i = 1'b0;
  logic [W-1:0] wr_data_i = '0;
  logic [W-1:0] rd_data_o;
  logic [N-1:0] irq_o;

  int checks = 0;
  int errors = 0;
  logic [N-1:0] en_m = '0, st_m = '0, irq_m = '0;
  logic [31:0]  lfsr = 32'h1234_5678;

  always #10 clk_i = ~clk_i;

  tmr_irq_csr #(.NUM_CH(N), .DATA_W(W)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .expire_i(expire_i), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk({req, " word"}, rd_data_o, {22'd0, st_m, en_m});
    chk({req, " irq"}, {27'd0, irq_o}, {27'd0, irq_m});
  endtask

  // drive at negedge, model advances one edge, compare at next negedge
  task automatic cyc(input logic [N-1:0] ev, input logic we, input logic [W-1:0] wd, input string req);
    logic [N-1:0] clr;
    expire_i  = ev;
    wr_en_i   = we;
    wr_data_i = wd;
    @(negedge clk_i);
    clr = we ? wd[2*N-1:N] : '0;
    for (int i = 0; i < N; i++) begin
      if (ev[i] && en_m[i])      irq_m[i] = 1'b1;
      else if (clr[i] && !ev[i]) irq_m[i] = 1'b0;
      if (ev[i])                 st_m[i] = 1'b1;
      else if (clr[i])           st_m[i] = 1'b0;
    end
    if (we) en_m = wd[N-1:0];
    expire_i = '0;
    wr_en_i  = 1'b0;
    chk_all(req);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 reset word", rd_data_o, 32'd0);
    chk("R1 reset irq", {27'd0, irq_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_all("R1 idle");

    cyc('0, 1'b1, 32'h15, "R2 set");
    chk("R2 en field", rd_data_o[4:0], 32'h15);
    cyc('0, 1'b1, 32'h0A, "R2 swap");
    chk("R2 en field", rd_data_o[4:0], 32'h0A);
    cyc('0, 1'b1, 32'h00, "R2 clear");

    cyc(5'b00100, 1'b0, '0, "R3 disabled event");
    chk("R3 bit7", rd_data_o[7], 32'd1);
    chk("R4 disabled irq2", irq_o[2], 32'd0);

    cyc('0, 1'b1, 32'h02, "R2 en1");
    cyc(5'b00010, 1'b0, '0, "R4 enabled event");
    chk("R4 irq1", irq_o[1], 32'd1);

    cyc('0, 1'b1, 32'h80 | 32'h02, "R5 clear ch2");
    chk("R5 bit7 cleared", rd_data_o[7], 32'd0);
    chk("R5 bit6 kept", rd_data_o[6], 32'd1);

    cyc('0, 1'b1, 32'h40 | 32'h02, "R6 clear ch1");
    chk("R6 irq1 low", irq_o[1], 32'd0);

    cyc(5'b01000, 1'b0, '0, "R9 pend ch3");
    cyc('0, 1'b1, 32'h08, "R9 late enable");
    chk("R9 irq3 stays low", irq_o[3], 32'd0);
    cyc('0, 1'b1, 32'h01, "R9 en0");
    cyc(5'b00001, 1'b0, '0, "R9 event ch0");
    cyc('0, 1'b1, 32'h00, "R9 disable");
    chk("R9 irq0 held", irq_o[0], 32'd1);

    cyc('0, 1'b1, 32'h3E0, "R6 clear all");
    cyc(5'b10000, 1'b1, 32'h10, "R10 enable same cycle");
    chk("R10 irq4 low", irq_o[4], 32'd0);
    chk("R10 bit9 set", rd_data_o[9], 32'd1);
    cyc(5'b10000, 1'b1, 32'h00, "R10 disable same cycle");
    chk("R10 irq4 high", irq_o[4], 32'd1);

    cyc('0, 1'b1, 32'hFFFF_FC00 | 32'h03, "R7 high write");
    chk("R7 high bits", rd_data_o[31:10], 32'd0);

    cyc('0, 1'b1, 32'h3E1, "R8 prep");
    cyc(5'b00001, 1'b0, '0, "R8 arm");
    cyc(5'b00001, 1'b1, 32'h21, "R8 collide enabled");
    chk("R8 bit5 kept", rd_data_o[5], 32'd1);
    chk("R8 irq0", irq_o[0], 32'd1);
    cyc(5'b00010, 1'b1, 32'h40, "R8 collide disabled");
    chk("R8 bit6 kept", rd_data_o[6], 32'd1);

    for (int e = 0; e < 32; e++) begin
      for (int v = 0; v < 32; v++) begin
        cyc('0, 1'b1, 32'h3E0 | e, "R2 sweep setup");
        cyc(v[N-1:0], 1'b0, '0, "R3/R4 sweep");
      end
    end

    for (int k = 0; k < 8000; k++) begin
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      cyc(lfsr[4:0] & lfsr[9:5], lfsr[10], {lfsr[31:12], 2'b00, lfsr[21:12]},
          "R5/R8/R10 walk");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule